// File: doc/BRIEF.md
# Queued-Operation SPI Flash Master

This block is a manual-mode SPI master for serial flash devices. Software does not set a bus width, direction or chip-select level in configuration registers. It queues operation words instead. Each word carries a 5-bit operation code and a 9-bit byte count. A word either sets the chip-select level or runs one transmit or receive phase of up to 511 bytes. Each phase runs on one, two or four data lines.

A byte-wide data FIFO is shared by both directions:

- While a transmit operation runs, the serializer drains the data FIFO.
- While a receive operation runs, the serializer fills it, and software reads it one byte at a time through a show-ahead read port with a pop strobe.

The serial clock comes from a fixed divider. It idles low (mode 0): output lanes change only while SCK is low, and input lanes are sampled when SCK rises. Longer transfers are split by software into several queued operations. Chip select stays asserted across them until a deassert operation is queued.

Top module: `spi_opq_master`

## Requirements
- R1: An operation word is 14 bits: byte count in bits 8:0 and operation code in bits 13:9. Loading it into the holding register (`op_word_we`) enqueues nothing; only an `op_commit` strobe enqueues the held word.
- R2: Operation code 0x01 drives `cs_n` low and code 0x00 drives it high; `cs_n` changes at no other time.
- R3: Code 0x08 transmits on lane 0 only, most significant bit first, with `io_oe` = 4'b0001 and 8 SCK cycles per byte.
- R4: Code 0x09 transmits bit pairs on lanes 1:0 with 4 SCK cycles per byte. Code 0x0A transmits nibbles on lanes 3:0 with 2 SCK cycles per byte. In both, the most significant group goes first and the highest bit of a group sits on the highest lane.
- R5: Codes 0x0C, 0x0E and 0x0F receive at one, two and four lanes. Single-lane input is taken from `io_in[1]`, dual from `io_in[1:0]` and quad from `io_in[3:0]`. Groups are assembled most significant first, and `io_oe` is 0 throughout a receive.
- R6: A transfer operation moves exactly its byte count; a count of 0 produces no SCK edge.
- R7: When a transmit operation finds the data FIFO empty, SCK stays low and no byte is lost; the transfer resumes when data arrives.
- R8: When a receive operation finds the data FIFO full, it starts no further byte and SCK stays low until software pops.
- R9: `dat_rdata` shows the oldest byte of the data FIFO and holds it until a `dat_pop` strobe, which advances to the next byte.
- R10: Each FIFO reports full and empty flags; an operation committed while the operation FIFO is full is dropped.
- R11: `op_empty` falls on the edge that accepts a commit and rises only after the last queued operation has completed on the bus.
- R12: SCK idles low, each high and low phase lasts HALF_PERIOD clock cycles, and `io_out` is stable while SCK is high.
- R13: After reset: `cs_n`=1, `sck`=0, `io_oe`=0, both FIFOs empty and not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_word_we | input | 1 | Load `op_word_in` into the holding register |
| op_word_in | input | 14 | Operation word {code[4:0], count[8:0]} |
| op_commit | input | 1 | Enqueue the held operation word |
| op_full | output | 1 | Operation FIFO full |
| op_empty | output | 1 | Queue empty and last operation complete |
| dat_we | input | 1 | Push `dat_wdata` into the data FIFO (ignored during a receive) |
| dat_wdata | input | 8 | Transmit byte |
| dat_full | output | 1 | Data FIFO full |
| dat_empty | output | 1 | Data FIFO empty |
| dat_pop | input | 1 | Advance the data FIFO read port (ignored during a transmit) |
| dat_rdata | output | 8 | Oldest byte in the data FIFO |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Output lane values |
| io_oe | output | 4 | Output lane enables |
| io_in | input | 4 | Input lane values |

## Verification
The bench drives inputs and samples outputs on falling clock edges. Flag results are due as follows:

- A commit clears `op_empty` at the very next rising edge.
- A queued chip-select operation changes `cs_n` one edge after that, when the sequencer takes it from the queue.
- A data pop shows the next byte on `dat_rdata` one edge later.

Serial results have no fixed latency, because they depend on data availability. For those, the bench waits on `op_empty` and then compares what its responder model captured or supplied against bench-computed expectations. Stall cases are checked by holding for a fixed window and confirming that the count of SCK rising edges equals exactly the number the requirement allows.

// File: rtl/opq_pkg.sv
package opq_pkg;
  localparam int CNT_W  = 9;
  localparam int CODE_W = 5;
  localparam int WORD_W = CNT_W + CODE_W;

  localparam logic [CODE_W-1:0] OPC_CS_HI = 5'h00;
  localparam logic [CODE_W-1:0] OPC_CS_LO = 5'h01;
  localparam logic [CODE_W-1:0] OPC_TX1   = 5'h08;
  localparam logic [CODE_W-1:0] OPC_TX2   = 5'h09;
  localparam logic [CODE_W-1:0] OPC_TX4   = 5'h0A;
  localparam logic [CODE_W-1:0] OPC_RX1   = 5'h0C;
  localparam logic [CODE_W-1:0] OPC_RX2   = 5'h0E;
  localparam logic [CODE_W-1:0] OPC_RX4   = 5'h0F;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  count;
  } op_word_t;

  typedef enum logic [1:0] {LW_1, LW_2, LW_4} lane_w_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_SHIFT} sq_state_e;

  function automatic logic [3:0] lane_mask(lane_w_e w);
    case (w)
      LW_2:    return 4'b0011;
      LW_4:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] group_steps(lane_w_e w);
    case (w)
      LW_2:    return 4'd4;
      LW_4:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/opq_fifo.sv
module opq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q, cnt_n;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign cnt_n = cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (do_wr) wp_q <= (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (do_rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_n;
      full  <= (cnt_n == CAP);
      empty <= (cnt_n == '0);
    end
  end

  // R10: a write offered while full cannot lower the fill level
  assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> full);

  // R10: both flags never assert together
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/opq_shifter.sv
module opq_shifter
  import opq_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] byte_in,
  input  lane_w_e    lanes,
  input  logic [3:0] io_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] byte_out,
  output logic       sck,
  output logic [3:0] io_out
);
  localparam int DW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_PERIOD-1);

  logic [7:0]    tx_q, rx_q;
  logic [3:0]    step_q;
  logic [DW-1:0] div_q;
  lane_w_e       lw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      step_q <= '0;
      div_q  <= '0;
      lw_q   <= LW_1;
      busy   <= 1'b0;
      done   <= 1'b0;
      sck    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          tx_q   <= byte_in;
          rx_q   <= '0;
          step_q <= group_steps(lanes);
          lw_q   <= lanes;
          div_q  <= '0;
          busy   <= 1'b1;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sck) begin
          sck <= 1'b1;
          case (lw_q)
            LW_2:    rx_q <= {rx_q[5:0], io_in[1:0]};
            LW_4:    rx_q <= {rx_q[3:0], io_in};
            default: rx_q <= {rx_q[6:0], io_in[1]};
          endcase
        end else begin
          sck <= 1'b0;
          case (lw_q)
            LW_2:    tx_q <= {tx_q[5:0], 2'b00};
            LW_4:    tx_q <= {tx_q[3:0], 4'b0000};
            default: tx_q <= {tx_q[6:0], 1'b0};
          endcase
          step_q <= step_q - 4'd1;
          if (step_q == 4'd1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  always_comb begin
    case (lw_q)
      LW_2:    io_out = {2'b00, tx_q[7:6]};
      LW_4:    io_out = tx_q[7:4];
      default: io_out = {3'b000, tx_q[7]};
    endcase
  end

  assign byte_out = rx_q;

  // R12: the clock rests low whenever no byte is in flight
  assert_sck_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  // R12: output lanes hold still across a high phase
  assert_io_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(io_out));
endmodule

// File: rtl/spi_opq_master.sv
module spi_opq_master
  import opq_pkg::*;
#(
  parameter int OP_DEPTH    = 8,
  parameter int DAT_DEPTH   = 16,
  parameter int HALF_PERIOD = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_word_we,
  input  logic [13:0] op_word_in,
  input  logic        op_commit,
  output logic        op_full,
  output logic        op_empty,
  input  logic        dat_we,
  input  logic [7:0]  dat_wdata,
  output logic        dat_full,
  output logic        dat_empty,
  input  logic        dat_pop,
  output logic [7:0]  dat_rdata,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  op_word_t  hold_q, head;
  logic      opf_empty, opf_rd;
  sq_state_e state_q;
  logic      cur_rx_q;
  lane_w_e   cur_lw_q;
  logic [CNT_W-1:0] remain_q;

  logic    hd_xfer, hd_rx;
  lane_w_e hd_lw;

  logic       sh_busy, sh_done, sh_start;
  logic [7:0] sh_rx_byte;
  logic       seq_pop, seq_push, rx_own, tx_own;
  logic       df_wr, df_rd;
  logic [7:0] df_wdata;

  always_ff @(posedge clk) begin
    if (rst)             hold_q <= '0;
    else if (op_word_we) hold_q <= op_word_t'(op_word_in);
  end

  opq_fifo #(.W(WORD_W), .DEPTH(OP_DEPTH)) u_opf (
    .clk(clk), .rst(rst),
    .wr_en(op_commit), .wdata(hold_q),
    .rd_en(opf_rd), .rdata(head),
    .full(op_full), .empty(opf_empty)
  );

  always_comb begin
    hd_xfer = 1'b1;
    hd_rx   = 1'b0;
    hd_lw   = LW_1;
    case (head.code)
      OPC_TX1: ;
      OPC_TX2: hd_lw = LW_2;
      OPC_TX4: hd_lw = LW_4;
      OPC_RX1: hd_rx = 1'b1;
      OPC_RX2: begin hd_rx = 1'b1; hd_lw = LW_2; end
      OPC_RX4: begin hd_rx = 1'b1; hd_lw = LW_4; end
      default: hd_xfer = 1'b0;
    endcase
  end

  assign opf_rd   = (state_q == SQ_IDLE) && !opf_empty;
  assign rx_own   = (state_q != SQ_IDLE) && cur_rx_q;
  assign tx_own   = (state_q != SQ_IDLE) && !cur_rx_q;
  assign sh_start = (state_q == SQ_XFER) && !sh_busy &&
                    (cur_rx_q ? !dat_full : !dat_empty);
  assign seq_pop  = sh_start && !cur_rx_q;
  assign seq_push = (state_q == SQ_SHIFT) && sh_done && cur_rx_q;

  assign df_wr    = rx_own ? seq_push : dat_we;
  assign df_wdata = rx_own ? sh_rx_byte : dat_wdata;
  assign df_rd    = tx_own ? seq_pop : dat_pop;

  opq_fifo #(.W(8), .DEPTH(DAT_DEPTH)) u_datf (
    .clk(clk), .rst(rst),
    .wr_en(df_wr), .wdata(df_wdata),
    .rd_en(df_rd), .rdata(dat_rdata),
    .full(dat_full), .empty(dat_empty)
  );

  opq_shifter #(.HALF_PERIOD(HALF_PERIOD)) u_shift (
    .clk(clk), .rst(rst),
    .start(sh_start), .byte_in(dat_rdata), .lanes(cur_lw_q),
    .io_in(io_in),
    .busy(sh_busy), .done(sh_done), .byte_out(sh_rx_byte),
    .sck(sck), .io_out(io_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      cur_rx_q <= 1'b0;
      cur_lw_q <= LW_1;
      remain_q <= '0;
      cs_n     <= 1'b1;
      io_oe    <= 4'b0000;
      op_empty <= 1'b1;
    end else begin
      op_empty <= opf_empty && (state_q == SQ_IDLE) && !op_commit;
      case (state_q)
        SQ_IDLE: begin
          if (!opf_empty) begin
            if (head.code == OPC_CS_LO)      cs_n <= 1'b0;
            else if (head.code == OPC_CS_HI) cs_n <= 1'b1;
            else if (hd_xfer && head.count != '0) begin
              state_q  <= SQ_XFER;
              cur_rx_q <= hd_rx;
              cur_lw_q <= hd_lw;
              remain_q <= head.count;
              io_oe    <= hd_rx ? 4'b0000 : lane_mask(hd_lw);
            end
          end
        end
        SQ_XFER: begin
          if (sh_start) state_q <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          if (sh_done) begin
            remain_q <= remain_q - CNT_W'(1);
            if (remain_q == CNT_W'(1)) begin
              state_q <= SQ_IDLE;
              io_oe   <= 4'b0000;
            end else begin
              state_q <= SQ_XFER;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R11: the empty report implies the sequencer is at rest
  assert_empty_means_idle_R11: assert property (@(posedge clk) disable iff (rst)
    op_empty |-> (state_q == SQ_IDLE));

  // R5: no lane is driven while a receive is in progress
  assert_rx_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    ((state_q != SQ_IDLE) && cur_rx_q) |-> (io_oe == 4'b0000));

  // R8: a received byte always finds room in the data FIFO
  assert_rx_room_R8: assert property (@(posedge clk) disable iff (rst)
    seq_push |-> !dat_full);

  // R2: chip select moves only while operations are being taken from the queue
  assert_cs_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> ($past(state_q) == SQ_IDLE));
endmodule

// File: tb/spi_opq_master_bench.sv
module spi_opq_master_bench;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        op_word_we = 1'b0;
  logic [13:0] op_word_in = '0;
  logic        op_commit = 1'b0;
  logic        op_full, op_empty;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic        dat_full, dat_empty;
  logic        dat_pop = 1'b0;
  logic [7:0]  dat_rdata;
  logic        sck, cs_n;
  logic [3:0]  io_out, io_oe, io_in;

  spi_opq_master #(.OP_DEPTH(8), .DAT_DEPTH(16), .HALF_PERIOD(HALF)) u_spi_opq_master (
    .clk(clk), .rst(rst),
    .op_word_we(op_word_we), .op_word_in(op_word_in), .op_commit(op_commit),
    .op_full(op_full), .op_empty(op_empty),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_full(dat_full), .dat_empty(dat_empty),
    .dat_pop(dat_pop), .dat_rdata(dat_rdata),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // responder model state
  logic [7:0] cap [64];
  int cap_n = 0;
  logic [7:0] acc = '0;
  int acc_bits = 0;
  logic [7:0] rsp [64];
  int rsp_i = 0;
  int rsp_bit = 0;
  int rx_w = 1;
  int sck_rises = 0;
  int hi_run = 0;
  int last_hi = 0;
  logic [7:0] txv [64];

  always @(posedge sck) begin
    sck_rises = sck_rises + 1;
    if (!cs_n) begin
      if (io_oe != 4'b0000) begin
        case ($countones(io_oe))
          1: begin acc = {acc[6:0], io_out[0]};   acc_bits = acc_bits + 1; end
          2: begin acc = {acc[5:0], io_out[1:0]}; acc_bits = acc_bits + 2; end
          default: begin acc = {acc[3:0], io_out}; acc_bits = acc_bits + 4; end
        endcase
        if (acc_bits >= 8) begin
          cap[cap_n & 63] = acc;
          cap_n = cap_n + 1;
          acc_bits = 0;
        end
      end else begin
        rsp_bit = rsp_bit + rx_w;
        if (rsp_bit >= 8) begin
          rsp_bit = 0;
          rsp_i = rsp_i + 1;
        end
      end
    end
  end

  always_comb begin
    logic [7:0] b;
    b = rsp[rsp_i & 63];
    case (rx_w)
      2:       io_in = {2'b00, b[7-rsp_bit -: 2]};
      4:       io_in = b[7-rsp_bit -: 4];
      default: io_in = {2'b00, b[7-rsp_bit], 1'b0};
    endcase
  end

  always @(negedge clk) begin
    if (sck) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [4:0] tx_code(int w);
    return (w == 4) ? 5'h0A : (w == 2) ? 5'h09 : 5'h08;
  endfunction
  function automatic logic [4:0] rx_code(int w);
    return (w == 4) ? 5'h0F : (w == 2) ? 5'h0E : 5'h0C;
  endfunction
  function automatic int exp_rises(int len, int w);
    return len * (8 / w);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic [4:0] code, input int len);
    @(negedge clk);
    op_word_we = 1'b1;
    op_word_in = {code, 9'(len)};
    @(negedge clk);
    op_word_we = 1'b0;
    op_commit = 1'b1;
    @(negedge clk);
    op_commit = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (dat_full) @(negedge clk);
    dat_we = 1'b1;
    dat_wdata = b;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    int guard;
    guard = 0;
    @(negedge clk);
    while (dat_empty && guard < 5000) begin @(negedge clk); guard++; end
    b = dat_rdata;
    dat_pop = 1'b1;
    @(negedge clk);
    dat_pop = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!op_empty && guard < 20000) begin @(negedge clk); guard++; end
    chk(op_empty, req, 0, 1);
  endtask

  task automatic model_clear();
    cap_n = 0; acc_bits = 0; rsp_i = 0; rsp_bit = 0; sck_rises = 0;
  endtask

  task automatic run_tx(input int w, input int len, input string req);
    model_clear();
    for (int i = 0; i < len; i++) begin
      txv[i] = 8'($urandom);
      push(txv[i]);
    end
    op(tx_code(w), len);
    wait_done(req);
    chk(cap_n == len, req, cap_n, len);
    chk(sck_rises == exp_rises(len, w), req, sck_rises, exp_rises(len, w));
    for (int i = 0; i < len; i++)
      if (cap[i] !== txv[i]) chk(1'b0, req, int'(cap[i]), int'(txv[i]));
  endtask

  task automatic run_rx(input int w, input int len, input string req);
    logic [7:0] got;
    model_clear();
    for (int i = 0; i < 64; i++) rsp[i] = 8'($urandom);
    rx_w = w;
    op(rx_code(w), len);
    wait_done(req);
    chk(sck_rises == exp_rises(len, w), req, sck_rises, exp_rises(len, w));
    for (int i = 0; i < len; i++) begin
      pop(got);
      if (got !== rsp[i]) chk(1'b0, req, int'(got), int'(rsp[i]));
    end
    chk(dat_empty, req, int'(dat_empty), 1);
  endtask

  initial begin
    logic [7:0] got;
    int unsigned seed;
    int saved;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) rsp[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    chk(cs_n == 1'b1 && sck == 1'b0 && io_oe == 4'b0000, "R13", int'({cs_n, sck, io_oe}), 32);
    chk(op_empty && !op_full && dat_empty && !dat_full, "R13",
        int'({op_empty, op_full, dat_empty, dat_full}), 4'b1010);

    // R1: loading the holding register alone enqueues nothing
    @(negedge clk);
    op_word_we = 1'b1;
    op_word_in = {5'h01, 9'd1};
    @(negedge clk);
    op_word_we = 1'b0;
    repeat (20) @(negedge clk);
    chk(op_empty && cs_n, "R1", int'({op_empty, cs_n}), 3);

    // R11: op_empty falls on the commit edge; R2: chip select asserts
    @(negedge clk);
    op_commit = 1'b1;
    @(negedge clk);
    op_commit = 1'b0;
    chk(!op_empty, "R11", int'(op_empty), 0);
    @(negedge clk);
    chk(cs_n == 1'b0, "R2", int'(cs_n), 0);
    wait_done("R11");

    // R3 / R4 directed widths
    run_tx(1, 5, "R3");
    chk(last_hi == HALF, "R12", last_hi, HALF);
    run_tx(2, 7, "R4");
    run_tx(4, 9, "R4");

    // R5 directed receive widths
    run_rx(1, 6, "R5");
    run_rx(2, 5, "R5");
    run_rx(4, 8, "R5");

    // R6: zero-length transfer produces no clock
    model_clear();
    op(5'h08, 0);
    wait_done("R6");
    chk(sck_rises == 0, "R6", sck_rises, 0);

    // R7: transmit stalls with no data
    model_clear();
    op(5'h08, 3);
    repeat (60) @(negedge clk);
    chk(sck_rises == 0 && !op_empty && sck == 1'b0, "R7", sck_rises, 0);
    for (int i = 0; i < 3; i++) begin txv[i] = 8'($urandom); push(txv[i]); end
    wait_done("R7");
    chk(cap_n == 3, "R7", cap_n, 3);
    for (int i = 0; i < 3; i++)
      if (cap[i] !== txv[i]) chk(1'b0, "R7", int'(cap[i]), int'(txv[i]));

    // R8 / R9: receive of 20 into a 16-deep FIFO stalls
    model_clear();
    for (int i = 0; i < 64; i++) rsp[i] = 8'($urandom);
    rx_w = 1;
    op(5'h0C, 20);
    repeat (1500) @(negedge clk);
    chk(dat_full && !op_empty, "R8", int'({dat_full, op_empty}), 2);
    chk(sck_rises == 128, "R8", sck_rises, 128);
    chk(dat_rdata == rsp[0], "R9", int'(dat_rdata), int'(rsp[0]));
    repeat (10) @(negedge clk);
    chk(dat_rdata == rsp[0], "R9", int'(dat_rdata), int'(rsp[0]));
    pop(got);
    chk(dat_rdata == rsp[1], "R9", int'(dat_rdata), int'(rsp[1]));
    for (int i = 1; i < 20; i++) begin
      pop(got);
      if (got !== rsp[i]) chk(1'b0, "R8", int'(got), int'(rsp[i]));
    end
    wait_done("R8");
    chk(sck_rises == 160, "R8", sck_rises, 160);

    // R10: fill the op FIFO behind a stalled transmit, then drop one extra
    model_clear();
    op(5'h08, 1);
    for (int i = 0; i < 8; i++) op(5'h01, 1);
    chk(op_full, "R10", int'(op_full), 1);
    op(5'h00, 1);
    txv[0] = 8'hA5;
    push(txv[0]);
    wait_done("R10");
    chk(!op_full && cs_n == 1'b0, "R10", int'({op_full, cs_n}), 0);
    chk(cap_n == 1 && cap[0] == 8'hA5, "R10", int'(cap[0]), 8'hA5);

    // R11: when op_empty rises, all bytes are already on the bus
    model_clear();
    for (int i = 0; i < 4; i++) push(8'(i * 17 + 3));
    op(5'h0A, 4);
    chk(!op_empty, "R11", int'(op_empty), 0);
    saved = 0;
    while (!op_empty && saved < 5000) begin @(negedge clk); saved++; end
    chk(cap_n == 4, "R11", cap_n, 4);

    // constrained random mix
    for (int k = 0; k < 8; k++) begin
      int w, len;
      w = 1 << ($urandom % 3);
      len = 1 + ($urandom % 12);
      if ($urandom % 2) run_tx(w, len, (w == 1) ? "R3" : "R4");
      else              run_rx(w, len, "R5");
    end

    // R12 sck half period and idle level
    chk(last_hi == HALF && sck == 1'b0, "R12", last_hi, HALF);

    // R2 deassert
    op(5'h00, 1);
    wait_done("R2");
    chk(cs_n == 1'b1, "R2", int'(cs_n), 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule